// File: doc/BRIEF.md
# Lockable Secure Configuration Register Bank

This block holds the configuration registers of a security controller behind a simple 32-bit register bus. Each request carries a byte address, an access size and a secure attribute. The bank answers every request one clock later with a response strobe, an error flag and read data. It also raises a one-cycle illegal-access event whenever a non-secure master touches one of its secure-only registers.

The control register sits at word offset zero and holds a single sticky lock bit. Software sets the lock with a write of one, and cannot clear it afterwards. Only a global reset or a wake-from-standby pulse clears the lock. While the lock is set, the protected configuration registers ignore every write.

A system secure-enable input controls the control register. When secure mode is off, the control register can neither be written nor read back. Only aligned 32-bit accesses are legal. Narrower or misaligned accesses end with a bus error and change nothing.

Top module: `seccfg_bank`

## Requirements
- R1: A request whose size code is not word (size codes: 0 byte, 1 halfword, 2 word) or whose address bits [1:0] are nonzero returns `rsp_err`=1 with `rsp_rdata`=0 in the response cycle.
- R2: After reset, the control register reads 0x0000_0000, every configuration register reads CFG_RST, and `rsp_valid` and `illegal_evt` are 0.
- R3: The control register is at byte offset 0x000, and its bit 0 is the lock. A secure write with bit 0 set sets the lock. A write with bit 0 clear leaves the lock unchanged. Bits 31:1 always read as zero.
- R4: While the lock is set, secure writes to any configuration register leave its contents unchanged.
- R5: A one-cycle pulse on `standby_wake` clears the lock, and configuration writes are accepted again afterwards. When a wake pulse and a lock-setting write fall in the same cycle, the wake pulse takes priority.
- R6: A non-secure word access to the control register or to a configuration register completes with `rsp_err`=0 and `rsp_rdata`=0. A write from such an access is dropped. `illegal_evt` is 1 in that access's response cycle only.
- R7: While `sys_secure_en`=0, writes to the control register have no effect and reads of it return zero. The configuration registers remain accessible.
- R8: `rsp_err` and `illegal_evt` are never 1 together. An access that fails the size or alignment check raises no event and changes no register, even when it is non-secure.
- R9: Word accesses to offsets beyond the last configuration register read zero, ignore writes, and raise neither an error nor an event.
- R10: Configuration register k is at byte offset 4*(k+1). When the lock is clear, a secure write updates it, and a secure read returns the written value.
- R11: `rsp_valid` is 1 exactly in the cycle after each cycle with `req_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| req_secure | input | 1 | Secure attribute of the request |
| req_wdata | input | 32 | Write data |
| sys_secure_en | input | 1 | System-level secure mode enable |
| standby_wake | input | 1 | Wake-from-standby pulse; clears the lock |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Bus error for an illegal access size or alignment |
| rsp_rdata | output | 32 | Read data |
| illegal_evt | output | 1 | One-cycle pulse for a non-secure access to a secure-only register |

## Verification
The hardest state to reach is a set lock paired with each way it can be bypassed or released. Reaching it needs a prior secure write of one with secure mode enabled, followed by a configuration write that must be shown to have no effect.

The stimulus first builds known register contents. It then sets the lock, attempts overwrites, and reads the old values back through the bus. Next it toggles `sys_secure_en`, showing that the lock stays held but becomes invisible. Finally it releases the lock once through a wake pulse and once through a mid-run global reset, and writes and reads configuration again after each release.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Qualified actions of one request, produced by the decoder.
  typedef struct packed {
    logic size_err;  // illegal size or alignment
    logic ns_viol;   // non-secure access to a secure-only register
    logic ctrl_wr;   // write reaching the control register
    logic cfg_wr;    // write aimed at a configuration register
    logic ctrl_rd;   // read that may see the control register
    logic cfg_rd;    // read of a configuration register
  } dec_t;

endpackage

// File: rtl/seccfg_decode.sv
module seccfg_decode
  import seccfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_CFG  = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              secure,
  input  logic              sys_sec_en,
  output dec_t              dec,
  output logic [SEL_W-1:0]  cfg_sel
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             bad_shape;
  logic             shape_ok;
  logic             map_ctrl;
  logic             map_cfg;
  logic             sec_ok;

  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    bad_shape = (size != SZ_WORD) || (addr[1:0] != 2'b00);
    shape_ok  = valid && !bad_shape;
    map_ctrl  = (word_idx == '0);
    map_cfg   = (word_idx != '0) && (word_idx <= IDX_W'(N_CFG));
    sec_ok    = shape_ok && secure;

    dec.size_err = valid && bad_shape;
    dec.ns_viol  = shape_ok && !secure && (map_ctrl || map_cfg);
    dec.ctrl_wr  = sec_ok && write && map_ctrl && sys_sec_en;
    dec.cfg_wr   = sec_ok && write && map_cfg;
    dec.ctrl_rd  = sec_ok && !write && map_ctrl && sys_sec_en;
    dec.cfg_rd   = sec_ok && !write && map_cfg;
  end

  assign cfg_sel = SEL_W'(word_idx - IDX_W'(1));

endmodule

// File: rtl/seccfg_lock.sv
module seccfg_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic wake,
  output logic lock_q
);

  logic lock_d;
  logic lock_en;

  always_comb begin
    lock_en = set_req || wake;
    lock_d  = wake ? 1'b0 : 1'b1;   // wake wins over a same-cycle set
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/seccfg_cfg_regs.sv
module seccfg_cfg_regs #(
  parameter int unsigned         N_CFG   = 4,
  parameter int unsigned         CFG_W   = 32,
  parameter int unsigned         SEL_W   = 2,
  parameter logic [CFG_W-1:0]    CFG_RST = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_req,
  input  logic [SEL_W-1:0]                sel,
  input  logic [CFG_W-1:0]                wdata,
  input  logic                            lock,
  output logic [N_CFG-1:0][CFG_W-1:0]     cfg_q
);

  for (genvar g = 0; g < N_CFG; g++) begin : g_reg
    logic             en;
    logic [CFG_W-1:0] d;

    always_comb begin
      en = wr_req && !lock && (sel == SEL_W'(g));
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= CFG_RST;
      end else if (en) begin
        cfg_q[g] <= d;
      end
    end
  end

endmodule

// File: rtl/seccfg_rsp.sv
module seccfg_rsp
  import seccfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             err,
  input  logic             evt,
  input  logic [BUS_W-1:0] rdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_evt,
  output logic [BUS_W-1:0] rsp_rdata
);

  logic [BUS_W-1:0] rdata_d;

  always_comb begin
    rdata_d = (valid && !err) ? rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_evt   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid;
      rsp_err   <= valid && err;
      rsp_evt   <= valid && evt && !err;
      rsp_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/seccfg_bank.sv
module seccfg_bank
  import seccfg_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 8,
  parameter int unsigned      N_CFG   = 4,
  parameter int unsigned      CFG_W   = 32,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_secure,
  input  logic [31:0]       req_wdata,
  input  logic              sys_secure_en,
  input  logic              standby_wake,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              illegal_evt
);

  localparam int unsigned SEL_W = (N_CFG > 1) ? $clog2(N_CFG) : 1;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  dec_t                        dec;
  logic [SEL_W-1:0]            cfg_sel;
  logic                        lock_q;
  logic [N_CFG-1:0][CFG_W-1:0] cfg_q;
  logic [BUS_W-1:0]            rdata_d;

  seccfg_decode #(
    .ADDR_W (ADDR_W),
    .N_CFG  (N_CFG),
    .SEL_W  (SEL_W)
  ) u_decode (
    .valid      (req_valid),
    .write      (req_write),
    .addr       (req_addr),
    .size       (req_size),
    .secure     (req_secure),
    .sys_sec_en (sys_secure_en),
    .dec        (dec),
    .cfg_sel    (cfg_sel)
  );

  seccfg_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_req (dec.ctrl_wr && req_wdata[0]),
    .wake    (standby_wake),
    .lock_q  (lock_q)
  );

  seccfg_cfg_regs #(
    .N_CFG   (N_CFG),
    .CFG_W   (CFG_W),
    .SEL_W   (SEL_W),
    .CFG_RST (CFG_RST)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_req (dec.cfg_wr),
    .sel    (cfg_sel),
    .wdata  (req_wdata[CFG_W-1:0]),
    .lock   (lock_q),
    .cfg_q  (cfg_q)
  );

  always_comb begin
    rdata_d = '0;
    if (dec.ctrl_rd) begin
      rdata_d = {{(BUS_W-1){1'b0}}, lock_q};
    end else if (dec.cfg_rd) begin
      rdata_d = BUS_W'(cfg_q[cfg_sel]);
    end
  end

  seccfg_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid     (req_valid),
    .err       (dec.size_err),
    .evt       (dec.ns_viol),
    .rdata     (rdata_d),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_evt   (illegal_evt),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/seccfg_bank_chk.sv
module seccfg_bank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_CFG  = 4,
  parameter int unsigned CFG_W  = 32
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [ADDR_W-1:0]           req_addr,
  input logic [1:0]                  req_size,
  input logic                        req_secure,
  input logic                        sys_secure_en,
  input logic                        standby_wake,
  input logic                        rsp_valid,
  input logic                        rsp_err,
  input logic [31:0]                 rsp_rdata,
  input logic                        illegal_evt,
  input logic                        lock_q,
  input logic [N_CFG-1:0][CFG_W-1:0] cfg_q
);

  logic bad_shape;
  logic mapped;

  assign bad_shape = (req_size != 2'd2) || (req_addr[1:0] != 2'b00);
  assign mapped    = (req_addr[ADDR_W-1:2] <= (ADDR_W-2)'(N_CFG));

  p_size_err_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && bad_shape |=> rsp_err && rsp_rdata == 32'd0);

  p_ctrl_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && !req_write && !bad_shape && req_addr[ADDR_W-1:2] == '0
    |=> rsp_rdata[31:1] == 31'd0);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q && !standby_wake |=> lock_q);

  p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> $stable(cfg_q));

  p_wake_clear_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    standby_wake |=> !lock_q);

  p_ns_event_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && !bad_shape && !req_secure && mapped
    |=> illegal_evt && !rsp_err && rsp_rdata == 32'd0);

  p_ctrl_hidden_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && !req_write && req_addr == '0 && !sys_secure_en
    |=> rsp_rdata == 32'd0);

  p_err_evt_excl_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rsp_err && illegal_evt));

  p_err_no_change_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && bad_shape && !standby_wake |=> $stable(lock_q) && $stable(cfg_q));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && !bad_shape && !mapped
    |=> !rsp_err && !illegal_evt && rsp_rdata == 32'd0);

  p_rsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid && !illegal_evt);

endmodule

bind seccfg_bank seccfg_bank_chk #(
  .ADDR_W (ADDR_W),
  .N_CFG  (N_CFG),
  .CFG_W  (CFG_W)
) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .req_secure    (req_secure),
  .sys_secure_en (sys_secure_en),
  .standby_wake  (standby_wake),
  .rsp_valid     (rsp_valid),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .illegal_evt   (illegal_evt),
  .lock_q        (lock_q),
  .cfg_q         (cfg_q)
);

// File: tb/seccfg_bank_tb.sv
module seccfg_bank_tb;

  localparam int unsigned ADDR_W = 8;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic              req_secure;
  logic [31:0]       req_wdata;
  logic              sys_secure_en;
  logic              standby_wake;
  logic              rsp_valid;
  logic              rsp_err;
  logic [31:0]       rsp_rdata;
  logic              illegal_evt;

  seccfg_bank #(.ADDR_W(ADDR_W), .N_CFG(4), .CFG_W(32), .CFG_RST(32'h0)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_secure    (req_secure),
    .req_wdata     (req_wdata),
    .sys_secure_en (sys_secure_en),
    .standby_wake  (standby_wake),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .illegal_evt   (illegal_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic        err;
    logic        evt;
    logic [31:0] rdata;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk;
  int   n_bad;
  logic mon_en;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one access followed by one idle cycle; the expected response is queued.
  task automatic acc(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                     input logic sec, input logic [31:0] wd, input logic e_err,
                     input logic e_evt, input logic [31:0] e_rd, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = addr;
    req_size   = sz;
    req_secure = sec;
    req_wdata  = wd;
    e.err = e_err; e.evt = e_evt; e.rdata = e_rd; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_wdata  = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each response against the queue; an event outside a response is a failure.
  always @(negedge clk) begin
    if (mon_en) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_err == e.err && illegal_evt == e.evt && rsp_rdata == e.rdata,
                e.tag, "err/evt/rdata",
                {rsp_err, illegal_evt, 30'd0} ^ rsp_rdata,
                {e.err, e.evt, 30'd0} ^ e.rdata);
        end
      end else if (illegal_evt || rsp_err) begin
        check(1'b0, "R6", "event/error without response", {30'd0, illegal_evt, rsp_err}, 32'd0);
      end
    end
  end

  task automatic summary_and_finish();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary_and_finish();
  end

  localparam logic [1:0] W = 2'd2, H = 2'd1, B = 2'd0;

  initial begin
    n_chk = 0; n_bad = 0; mon_en = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = W; req_secure = 1'b1; req_wdata = '0;
    sys_secure_en = 1'b1; standby_wake = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    mon_en = 1'b1;

    // R2 reset state
    check(rsp_valid == 1'b0 && illegal_evt == 1'b0, "R2", "idle outputs after reset",
          {30'd0, rsp_valid, illegal_evt}, 32'd0);
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R2 ctrl reset");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'h0, "R2 cfg0 reset");

    // R10 secure configuration access
    acc(1, 8'h04, W, 1, 32'hA5A5_0001, 0, 0, 32'h0, "R10 write cfg0");
    acc(1, 8'h10, W, 1, 32'h1234_5678, 0, 0, 32'h0, "R10 write cfg3");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'hA5A5_0001, "R10 read cfg0");
    acc(0, 8'h10, W, 1, 0, 0, 0, 32'h1234_5678, "R10 read cfg3");

    // R1 / R8 size and alignment faults
    acc(1, 8'h04, B, 1, 32'hDEAD_BEEF, 1, 0, 32'h0, "R1 byte write");
    acc(0, 8'h08, H, 1, 0, 1, 0, 32'h0, "R1 halfword read");
    acc(0, 8'h06, W, 1, 0, 1, 0, 32'h0, "R1 misaligned word");
    acc(1, 8'h00, B, 0, 32'h1, 1, 0, 32'h0, "R8 ns byte to ctrl no event");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'hA5A5_0001, "R8 cfg0 unchanged after fault");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R8 lock unchanged after fault");

    // R6 non-secure accesses
    acc(1, 8'h08, W, 0, 32'h0000_FFFF, 0, 1, 32'h0, "R6 ns write cfg1");
    acc(0, 8'h08, W, 1, 0, 0, 0, 32'h0, "R6 cfg1 write dropped");
    acc(0, 8'h04, W, 0, 0, 0, 1, 32'h0, "R6 ns read cfg0");
    acc(1, 8'h00, W, 0, 32'h1, 0, 1, 32'h0, "R6 ns write ctrl");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R6 lock not set by ns write");

    // R9 unmapped offsets
    acc(1, 8'h40, W, 1, 32'hFFFF_FFFF, 0, 0, 32'h0, "R9 write unmapped");
    acc(0, 8'h40, W, 1, 0, 0, 0, 32'h0, "R9 read unmapped");
    acc(0, 8'h14, W, 0, 0, 0, 0, 32'h0, "R9 ns unmapped no event");

    // R7 secure mode disabled
    @(negedge clk); sys_secure_en = 1'b0;
    acc(1, 8'h00, W, 1, 32'h1, 0, 0, 32'h0, "R7 ctrl write blocked");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R7 ctrl reads zero");
    acc(1, 8'h0C, W, 1, 32'h0000_000C, 0, 0, 32'h0, "R7 cfg2 write");
    acc(0, 8'h0C, W, 1, 0, 0, 0, 32'h0000_000C, "R7 cfg2 still accessible");
    @(negedge clk); sys_secure_en = 1'b1;
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R7 lock not set while disabled");

    // R3 lock bit
    acc(1, 8'h00, W, 1, 32'hFFFF_FFFE, 0, 0, 32'h0, "R3 reserved write");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R3 reserved bits read zero");
    acc(1, 8'h00, W, 1, 32'h0000_0001, 0, 0, 32'h0, "R3 set lock");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h1, "R3 lock reads one");
    acc(1, 8'h00, W, 1, 32'h0000_0000, 0, 0, 32'h0, "R3 clear attempt");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h1, "R3 lock sticky");

    // R4 frozen configuration
    acc(1, 8'h04, W, 1, 32'h0, 0, 0, 32'h0, "R4 write cfg0 locked");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'hA5A5_0001, "R4 cfg0 frozen");
    acc(1, 8'h10, W, 1, 32'h0, 0, 0, 32'h0, "R4 write cfg3 locked");
    acc(0, 8'h10, W, 1, 0, 0, 0, 32'h1234_5678, "R4 cfg3 frozen");
    acc(0, 8'h00, W, 0, 0, 0, 1, 32'h0, "R6 ns read of locked ctrl");

    // R7 with lock set: hidden, but still held
    @(negedge clk); sys_secure_en = 1'b0;
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R7 locked ctrl reads zero");
    @(negedge clk); sys_secure_en = 1'b1;
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h1, "R7 lock held while hidden");

    // R5 standby wake release
    @(negedge clk); standby_wake = 1'b1;
    @(negedge clk); standby_wake = 1'b0;
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R5 lock cleared by wake");
    acc(1, 8'h04, W, 1, 32'h0000_0007, 0, 0, 32'h0, "R5 write cfg0 after wake");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'h0000_0007, "R5 cfg0 writable after wake");

    // R5 wake and lock-setting write in the same cycle: wake wins
    @(negedge clk);
    standby_wake = 1'b1;
    acc(1, 8'h00, W, 1, 32'h1, 0, 0, 32'h0, "R5 set with wake");
    standby_wake = 1'b0;
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R5 wake beats set");

    // R2 global reset clears the lock and configuration
    acc(1, 8'h00, W, 1, 32'h1, 0, 0, 32'h0, "R3 relock");
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h1, "R3 relocked");
    idle(2);
    check(exp_q.size() == 0, "R11", "responses drained", exp_q.size(), 32'd0);
    mon_en = 1'b0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    mon_en = 1'b1;
    acc(0, 8'h00, W, 1, 0, 0, 0, 32'h0, "R2 lock cleared by reset");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'h0, "R2 cfg0 cleared by reset");
    acc(1, 8'h04, W, 1, 32'h0000_0055, 0, 0, 32'h0, "R10 write after reset");
    acc(0, 8'h04, W, 1, 0, 0, 0, 32'h0000_0055, "R10 read after reset");

    idle(3);
    check(exp_q.size() == 0, "R11", "all responses seen", exp_q.size(), 32'd0);
    summary_and_finish();
  end

endmodule